// File: doc/BRIEF.md
# Prescaled 64-bit Alarm Timer

One general-purpose timer channel, driven through a small word-wide register port. A 16-bit prescaler divides one of two synchronous tick-enable inputs. Each divided tick moves a 64-bit counter one step, either up or down. Software presets the counter in three writes: the low half of a preset value, the high half, and then a reload strobe. To read a coherent 64-bit count, software requests a snapshot, waits for the request flag to clear, and then reads the two captured halves.

A 64-bit compare value arms an alarm. When the alarm fires it disarms itself, sets an interrupt flag and, if enabled, puts the preset value back into the counter. A two-bit interrupt group holds raw flags, an enable mask, the masked status and write-one-to-clear. Bit 0 belongs to this channel's alarm. Bit 1 is set by a pulse on a peer event input. Two interrupt outputs are provided: a level line and a one-cycle edge pulse.

Top module: `alarm_timer64`

## Requirements
- R1: The counter steps once for every N selected ticks, where N is the 16-bit divider field at config bits [15:0]. A field value of 0 means N = 65536.
- R2: When config bit 17 is 1 the counter counts up, and when it is 0 it counts down. Both directions wrap modulo 2^64.
- R3: While config bit 16 (run) is 0, ticks do not change the counter.
- R4: A write to the reload strobe (address 3) copies the preset value into the counter. The preset's low half is at address 1 and its high half at address 2.
- R5: Writing 1 to bit 0 of address 4 sets a pending flag, which reads back on bit 0 of that address. On the next clock the live count is captured and the flag clears. Addresses 5 and 6 return the low and high halves of the captured count.
- R6: While config bit 19 (arm) is 1 and the counter equals the compare value, the alarm fires. The compare value's low half is at address 7 and its high half at address 8. When the alarm fires, raw bit 0 is set and the arm bit clears.
- R7: If config bit 18 is 1 when the alarm fires, the counter is loaded from the preset value.
- R8: Raw flags read at address 9. The enable mask is at address 10, and the status at address 11 equals raw AND mask. Writing ones to address 12 clears the matching raw bits. A pulse on peer_evt sets raw bit 1.
- R9: irq_level equals config bit 20 AND status bit 0. irq_edge is high for exactly the one cycle in which the alarm fires, provided config bit 21 is 1.
- R10: When config bit 22 is 1, tick_xtal is the tick source and tick_bus is ignored. When the bit is 0, the roles are reversed.
- R11: Any write to the config register (address 0) restarts the prescaler phase. After such a write, a full N ticks are needed before the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Read data for rd_addr (combinational) |
| tick_xtal | input | 1 | Tick enable from the crystal domain |
| tick_bus | input | 1 | Tick enable from the bus clock |
| peer_evt | input | 1 | Sets raw interrupt bit 1 |
| irq_level | output | 1 | Level interrupt |
| irq_edge | output | 1 | One-cycle alarm pulse |

## Verification
The assertions check the following on every cycle:
- the counter holds while stopped;
- a snapshot completes in one cycle and captures the prior count;
- a fired alarm disarms itself;
- auto-reload restores the preset value;
- the edge pulse lasts one cycle;
- a clear write drops raw bit 0.

Only the bench scenarios can show that the division ratio is right, including the 0-means-65536 case. The same applies to wrap-around in both directions, the rejection of the unselected tick source, phase restart on a config write, and the exact cycle on which the alarm outputs react.

// File: rtl/alarm_timer64.sv
module alarm_timer64 #(
  parameter int DIV_W = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  input  logic          tick_xtal,
  input  logic          tick_bus,
  input  logic          peer_evt,
  output logic          irq_level,
  output logic          irq_edge
);
  localparam int PADW = 32 - DIV_W - 7;
  localparam logic [AW-1:0] A_CFG = 0, A_PLO = 1, A_PHI = 2, A_RLD = 3, A_SNP = 4,
    A_CLO = 5, A_CHI = 6, A_MLO = 7, A_MHI = 8, A_RAW = 9, A_ENA = 10, A_STS = 11, A_CLR = 12;

  logic [DIV_W-1:0] div_q, phase_q;
  logic en_q, up_q, arl_q, arm_q, lvl_q, edg_q, xtal_q;
  logic [63:0] cnt_q, pre_q, cmp_q, snap_q;
  logic snap_busy_q;
  logic [1:0] raw_q, ena_q;

  wire cfg_wr = wr_en && wr_addr == A_CFG;
  wire rld_wr = wr_en && wr_addr == A_RLD;
  wire clr_wr = wr_en && wr_addr == A_CLR;
  wire tick_sel = xtal_q ? tick_xtal : tick_bus;
  wire last_ph = phase_q == ((div_q == '0) ? {DIV_W{1'b1}} : div_q - 1'b1);
  wire step = en_q && tick_sel && last_ph;
  wire hit = arm_q && cnt_q == cmp_q;
  wire [1:0] sts = raw_q & ena_q;

  assign irq_level = lvl_q & sts[0];
  assign irq_edge  = edg_q & hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0; phase_q <= '0;
      {en_q, up_q, arl_q, arm_q, lvl_q, edg_q, xtal_q} <= '0;
      cnt_q <= '0; pre_q <= '0; cmp_q <= '0; snap_q <= '0;
      snap_busy_q <= 1'b0; raw_q <= '0; ena_q <= '0;
    end else begin
      if (cfg_wr) phase_q <= '0;
      else if (en_q && tick_sel) phase_q <= last_ph ? '0 : phase_q + 1'b1;

      if (cfg_wr) begin
        div_q  <= wr_data[DIV_W-1:0];
        en_q   <= wr_data[DIV_W];
        up_q   <= wr_data[DIV_W+1];
        arl_q  <= wr_data[DIV_W+2];
        arm_q  <= wr_data[DIV_W+3];
        lvl_q  <= wr_data[DIV_W+4];
        edg_q  <= wr_data[DIV_W+5];
        xtal_q <= wr_data[DIV_W+6];
      end else if (hit) arm_q <= 1'b0;

      if (rld_wr) cnt_q <= pre_q;
      else if (hit && arl_q) cnt_q <= pre_q;
      else if (step) cnt_q <= up_q ? cnt_q + 64'd1 : cnt_q - 64'd1;

      if (wr_en && wr_addr == A_PLO) pre_q[31:0]  <= wr_data;
      if (wr_en && wr_addr == A_PHI) pre_q[63:32] <= wr_data;
      if (wr_en && wr_addr == A_MLO) cmp_q[31:0]  <= wr_data;
      if (wr_en && wr_addr == A_MHI) cmp_q[63:32] <= wr_data;
      if (wr_en && wr_addr == A_ENA) ena_q <= wr_data[1:0];

      if (snap_busy_q) begin
        snap_q <= cnt_q;
        snap_busy_q <= 1'b0;
      end else if (wr_en && wr_addr == A_SNP && wr_data[0]) snap_busy_q <= 1'b1;

      raw_q <= (raw_q & ~(clr_wr ? wr_data[1:0] : 2'b00)) | {peer_evt, hit};
    end
  end

  always_comb begin
    case (rd_addr)
      A_CFG:   rd_data = {{PADW{1'b0}}, xtal_q, edg_q, lvl_q, arm_q, arl_q, up_q, en_q, div_q};
      A_PLO:   rd_data = pre_q[31:0];
      A_PHI:   rd_data = pre_q[63:32];
      A_SNP:   rd_data = {31'd0, snap_busy_q};
      A_CLO:   rd_data = snap_q[31:0];
      A_CHI:   rd_data = snap_q[63:32];
      A_MLO:   rd_data = cmp_q[31:0];
      A_MHI:   rd_data = cmp_q[63:32];
      A_RAW:   rd_data = {30'd0, raw_q};
      A_ENA:   rd_data = {30'd0, ena_q};
      A_STS:   rd_data = {30'd0, sts};
      default: rd_data = '0;
    endcase
  end

  // R3
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q && !rld_wr && !(hit && arl_q) |=> $stable(cnt_q));
  // R5
  snap_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_busy_q |=> !snap_busy_q && snap_q == $past(cnt_q));
  // R6
  arm_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !cfg_wr |=> !arm_q && raw_q[0]);
  // R7
  auto_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && arl_q && !rld_wr |=> cnt_q == $past(pre_q));
  // R9
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_edge && !cfg_wr |=> !irq_edge);
  // R8
  clear_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && wr_data[0] && !hit |=> !raw_q[0]);
endmodule

// File: tb/alarm_timer64_test.sv
module alarm_timer64_test;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, wr_en = 0, tick_xtal = 0, tick_bus = 0, peer_evt = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic irq_level, irq_edge;
  int checks = 0, failures = 0;

  alarm_timer64 uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick_xtal(tick_xtal), .tick_bus(tick_bus),
    .peer_evt(peer_evt), .irq_level(irq_level), .irq_edge(irq_edge));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic preset(logic [63:0] v);
    wr(1, v[31:0]); wr(2, v[63:32]); wr(3, 0);
  endtask

  task automatic snapshot(output logic [63:0] v);
    logic [31:0] lo, hi;
    wr(4, 1);
    @(negedge clk);
    rd(5, lo); rd(6, hi);
    v = {hi, lo};
  endtask

  task automatic ticks(int n, bit xt);
    if (n > 0) begin
      if (xt) tick_xtal = 1; else tick_bus = 1;
      repeat (n) @(negedge clk);
      tick_xtal = 0; tick_bus = 0;
    end
  endtask

  function automatic logic [31:0] cfg(int dv, bit en, bit up, bit arl, bit arm, bit lvl, bit edg, bit xt);
    return {9'd0, xt, edg, lvl, arm, arl, up, en, dv[15:0]};
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] v, base, exp;
    logic [31:0] r;
    int divs[5] = '{1, 2, 3, 5, 7};
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    rd(0, r); check("R1 reset cfg", r, 0);
    rd(9, r); check("R8 reset raw", r, 0);
    check("R9 reset irq", {irq_level, irq_edge}, 0);

    // R1 R2: sweep of divider, direction and tick count, including wrap
    foreach (divs[i]) for (int up = 0; up < 2; up++) for (int n = 0; n < 10; n++) begin
      base = up ? 64'hFFFF_FFFF_FFFF_FFFE : 64'd1;
      wr(0, cfg(divs[i], 1, up[0], 0, 0, 0, 0, 0));
      preset(base);
      ticks(n, 0);
      snapshot(v);
      exp = up ? base + 64'(n / divs[i]) : base - 64'(n / divs[i]);
      check(up ? "R1 R2 count up" : "R1 R2 count down", v, exp);
    end

    // R4 preset of arbitrary halves
    wr(0, cfg(1, 0, 1, 0, 0, 0, 0, 0));
    preset(64'h1234_5678_9ABC_DEF0);
    snapshot(v); check("R4 reload", v, 64'h1234_5678_9ABC_DEF0);

    // R3 stopped
    ticks(6, 0); snapshot(v); check("R3 no count when stopped", v, 64'h1234_5678_9ABC_DEF0);

    // R5 pending flag
    wr(4, 1); rd(4, r); check("R5 pending set", r, 1);
    @(negedge clk); rd(4, r); check("R5 pending clears", r, 0);

    // R10 source select
    wr(0, cfg(1, 1, 1, 0, 0, 0, 0, 1)); preset(0);
    ticks(5, 0); snapshot(v); check("R10 bus ignored", v, 0);
    ticks(5, 1); snapshot(v); check("R10 xtal counts", v, 5);
    wr(0, cfg(1, 1, 1, 0, 0, 0, 0, 0));
    ticks(4, 1); snapshot(v); check("R10 xtal ignored", v, 5);
    ticks(4, 0); snapshot(v); check("R10 bus counts", v, 9);

    // R11 phase restart
    wr(0, cfg(4, 1, 1, 0, 0, 0, 0, 0)); preset(0);
    ticks(3, 0);
    wr(0, cfg(4, 1, 1, 0, 0, 0, 0, 0));
    ticks(3, 0); snapshot(v); check("R11 phase restarted", v, 0);
    ticks(1, 0); snapshot(v); check("R11 step after full N", v, 1);

    // R6 R9 alarm without reload
    wr(10, 1);
    wr(7, 32'd103); wr(8, 0);
    wr(0, cfg(1, 1, 1, 0, 0, 0, 0, 0)); preset(100);
    wr(0, cfg(1, 1, 1, 0, 1, 1, 1, 0));
    ticks(3, 0);
    #1; check("R9 edge pulse on fire", irq_edge, 1);
    @(negedge clk); #1;
    check("R9 edge one cycle", irq_edge, 0);
    check("R9 level follows status", irq_level, 1);
    rd(9, r); check("R6 raw set", r, 1);
    rd(0, r); check("R6 arm cleared", r[19], 0);
    snapshot(v); check("R6 no reload", v, 103);

    // R8 clear and peer
    wr(12, 1); #1; check("R8 clear raw", irq_level, 0);
    rd(9, r); check("R8 raw after clear", r, 0);
    peer_evt = 1; @(negedge clk); peer_evt = 0;
    rd(9, r); check("R8 peer sets bit1", r, 2);
    rd(11, r); check("R8 status masked", r, 0);
    wr(10, 3); rd(11, r); check("R8 status enabled", r, 2);
    wr(12, 2); rd(9, r); check("R8 clear bit1", r, 0);

    // R7 auto reload; R9 level disabled
    wr(10, 1);
    wr(7, 32'd52); wr(8, 0);
    wr(0, cfg(1, 1, 1, 1, 0, 0, 0, 0)); preset(50);
    wr(0, cfg(1, 1, 1, 1, 1, 0, 0, 0));
    ticks(2, 0);
    #1; check("R9 edge disabled", irq_edge, 0);
    @(negedge clk);
    snapshot(v); check("R7 autoreload", v, 50);
    check("R9 level disabled", irq_level, 0);
    rd(11, r); check("R7 status set", r, 1);
    wr(12, 1);

    // R1 divider 0 = 65536
    wr(0, cfg(0, 1, 1, 0, 0, 0, 0, 0)); preset(0);
    ticks(65535, 0); snapshot(v); check("R1 div0 before", v, 0);
    ticks(1, 0); snapshot(v); check("R1 div0 step", v, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule